// File: doc/BRIEF.md
# Four-Quadrant Signed Iterative Divider

This block divides a signed 32-bit dividend by a signed 16-bit divisor, both in two's complement, and returns a signed 16-bit quotient and a signed 16-bit remainder. It gives correctly signed results whichever of the two operands is negative. The dividend arrives as an upper and a lower 16-bit word.

When the block is idle, a one-cycle `start` pulse captures the operands and the `frac_mode` select. The block then turns the operands into magnitudes and records two signs: the dividend's sign, and the exclusive-or of the two operand signs. It runs one non-restoring shift-and-add/subtract step per clock for 16 clocks. In one final clock it restores the remainder, applies the signs and registers both results. `busy` covers the whole operation, and `done` pulses for one cycle when the results are updated.

In integer mode the operands are plain integers. In fractional mode the dividend is read as a 1.31 fraction and the divisor as a 1.15 fraction. The dividend magnitude is then aligned one bit to the right before iterating, so the quotient comes out as a 1.15 fraction. Divide-by-zero is not detected, and quotients too large for 16 bits are neither detected nor saturated.

Top module: `div4q_top`

## Requirements
- R1: While reset is held and in the first cycle after it, `busy`, `done`, `quot` and `rem` are all zero.
- R2: A `start` sampled high while `busy` is low raises `busy` at the next edge. `done` is high for exactly one cycle, beginning at the 17th rising edge after the accepting edge, and `busy` falls at that same edge.
- R3: A `start` pulse or an operand change while `busy` is high has no effect. The operation in flight keeps its timing and its results, and no second `done` follows.
- R4: In integer mode (`frac_mode` = 0), `quot` is the low 16 bits of D/V truncated toward zero, for all four sign combinations, provided |D| < |V|·2^16.
- R5: In integer mode, `rem` equals D − quot·V. It carries the sign of the dividend and has a magnitude below |V|.
- R6: In fractional mode (`frac_mode` = 1), with A = floor(|D|/2), `quot` is the low 16 bits of ±floor(A/|V|) and `rem` is ±(A mod |V|). The quotient is negative when exactly one operand is negative, the remainder takes the dividend's sign, and the result is valid when A < |V|·2^16.
- R7: `quot` and `rem` change only at the edge that raises `done`. Between operations they hold their values, even when the inputs change.
- R8: A dividend of −2^31 and a divisor of −32768 are handled through full-width magnitudes. For example, fractional −2^31 / −32768 gives `quot` = 16'h8000 and `rem` = 0.
- R9: A zero dividend gives a zero quotient and a zero remainder for either divisor sign. A negated zero must not appear as a nonzero pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation; sampled only while idle |
| frac_mode | input | 1 | 1 = fractional operands, 0 = integer operands |
| dvd_hi | input | 16 | Upper word of the signed dividend |
| dvd_lo | input | 16 | Lower word of the signed dividend |
| dvs | input | 16 | Signed divisor |
| busy | output | 1 | High while an operation is in progress |
| done | output | 1 | One-cycle pulse when new results are registered |
| quot | output | 16 | Signed quotient |
| rem | output | 16 | Signed remainder |

## Verification
The bench covers every sign quadrant in both modes, using operands that leave a nonzero remainder:
- A design that takes the remainder's sign from the quotient, or skips the restoring addition, returns a remainder off by |V| or with the wrong sign.
- The most-negative dividend and divisor are exercised. A design that takes magnitudes at 16 or 31 bits wraps them and produces garbage.
- A zero dividend with a negative divisor catches a sign fix-up that is wrong for zero.
- Start pulses and operand changes while busy, followed by idle cycles with changing inputs, catch a design that restarts mid-operation or lets its result registers follow the inputs.

// File: rtl/div4q_pkg.sv
package div4q_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_FIX  = 2'd2
   } div_state_e;

endpackage

// File: rtl/div4q_prep.sv
// Operand conditioning: sign capture, magnitudes, fractional alignment.
module div4q_prep #(
   parameter int DW = 16
) (
   input  logic [DW-1:0]   dvd_hi,
   input  logic [DW-1:0]   dvd_lo,
   input  logic [DW-1:0]   dvs,
   input  logic            frac_mode,
   output logic [2*DW-1:0] num_mag,
   output logic [DW-1:0]   dvs_mag,
   output logic            neg_dvd,
   output logic            neg_quo
);
   localparam int NW = 2*DW;

   logic [NW-1:0] num_raw;
   logic [NW-1:0] num_abs;

   assign num_raw = {dvd_hi, dvd_lo};
   assign neg_dvd = dvd_hi[DW-1];
   assign neg_quo = dvd_hi[DW-1] ^ dvs[DW-1];

   // Two's-complement negation of the most negative value yields its
   // unsigned magnitude, so no extra width is needed.
   assign num_abs = neg_dvd ? (~num_raw + NW'(1)) : num_raw;
   assign dvs_mag = dvs[DW-1] ? (~dvs + DW'(1)) : dvs;

   // Fractional alignment drops the dividend LSB.
   assign num_mag = frac_mode ? {1'b0, num_abs[NW-1:1]} : num_abs;

endmodule

// File: rtl/div4q_step.sv
// One non-restoring step: shift in a dividend bit, then add or subtract.
module div4q_step #(
   parameter int DW = 16
) (
   input  logic [DW+1:0] p_in,
   input  logic          bit_in,
   input  logic [DW-1:0] m_in,
   output logic [DW+1:0] p_out,
   output logic          q_bit
);
   localparam int PW = DW + 2;

   logic [PW-1:0] p_sh;
   logic [PW-1:0] m_ext;

   assign p_sh  = {p_in[PW-2:0], bit_in};
   assign m_ext = {2'b00, m_in};
   assign p_out = p_in[PW-1] ? (p_sh + m_ext) : (p_sh - m_ext);
   assign q_bit = ~p_out[PW-1];

endmodule

// File: rtl/div4q_fixup.sv
// Remainder restoration and sign correction of both results.
module div4q_fixup #(
   parameter int DW = 16
) (
   input  logic [DW+1:0] p_fin,
   input  logic [DW-1:0] q_raw,
   input  logic [DW-1:0] m_in,
   input  logic          neg_dvd,
   input  logic          neg_quo,
   output logic [DW-1:0] quot_fix,
   output logic [DW-1:0] rem_fix
);
   localparam int PW = DW + 2;

   logic [PW-1:0] p_rest;
   logic [DW-1:0] rem_mag;

   assign p_rest   = p_fin[PW-1] ? (p_fin + {2'b00, m_in}) : p_fin;
   assign rem_mag  = p_rest[DW-1:0];
   assign rem_fix  = neg_dvd ? (~rem_mag + DW'(1)) : rem_mag;
   assign quot_fix = neg_quo ? (~q_raw + DW'(1)) : q_raw;

endmodule

// File: rtl/div4q_top.sv
module div4q_top #(
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          frac_mode,
   input  logic [DW-1:0] dvd_hi,
   input  logic [DW-1:0] dvd_lo,
   input  logic [DW-1:0] dvs,
   output logic          busy,
   output logic          done,
   output logic [DW-1:0] quot,
   output logic [DW-1:0] rem
);
   import div4q_pkg::*;

   localparam int NW = 2*DW;
   localparam int PW = DW + 2;
   localparam int CW = $clog2(DW + 1);
   localparam logic [CW-1:0] LAST_STEP = CW'(DW - 1);

   generate
      if (DW < 4) begin : g_dw_check
         $error("div4q_top: DW must be at least 4");
      end
   endgenerate

   div_state_e    state_q;
   logic [CW-1:0] step_q;
   logic [PW-1:0] p_q;
   logic [DW-1:0] y_q;
   logic [DW-1:0] m_q;
   logic          neg_dvd_q;
   logic          neg_quo_q;

   logic [NW-1:0] num_mag;
   logic [DW-1:0] dvs_mag;
   logic          neg_dvd;
   logic          neg_quo;
   logic [PW-1:0] p_next;
   logic          q_bit;
   logic [DW-1:0] quot_fix;
   logic [DW-1:0] rem_fix;

   div4q_prep #(.DW(DW)) u_prep (
      .dvd_hi   (dvd_hi),
      .dvd_lo   (dvd_lo),
      .dvs      (dvs),
      .frac_mode(frac_mode),
      .num_mag  (num_mag),
      .dvs_mag  (dvs_mag),
      .neg_dvd  (neg_dvd),
      .neg_quo  (neg_quo)
   );

   div4q_step #(.DW(DW)) u_step (
      .p_in  (p_q),
      .bit_in(y_q[DW-1]),
      .m_in  (m_q),
      .p_out (p_next),
      .q_bit (q_bit)
   );

   div4q_fixup #(.DW(DW)) u_fixup (
      .p_fin   (p_q),
      .q_raw   (y_q),
      .m_in    (m_q),
      .neg_dvd (neg_dvd_q),
      .neg_quo (neg_quo_q),
      .quot_fix(quot_fix),
      .rem_fix (rem_fix)
   );

   assign busy = (state_q != ST_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         step_q    <= '0;
         p_q       <= '0;
         y_q       <= '0;
         m_q       <= '0;
         neg_dvd_q <= 1'b0;
         neg_quo_q <= 1'b0;
         done      <= 1'b0;
         quot      <= '0;
         rem       <= '0;
      end else begin
         done <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (start) begin
                  // The upper word always lies below the divisor magnitude
                  // for valid operands, so the first step starts non-negative.
                  p_q       <= {2'b00, num_mag[NW-1:DW]};
                  y_q       <= num_mag[DW-1:0];
                  m_q       <= dvs_mag;
                  neg_dvd_q <= neg_dvd;
                  neg_quo_q <= neg_quo;
                  step_q    <= '0;
                  state_q   <= ST_RUN;
               end
            end
            ST_RUN: begin
               p_q    <= p_next;
               y_q    <= {y_q[DW-2:0], q_bit};
               step_q <= step_q + CW'(1);
               if (step_q == LAST_STEP) begin
                  state_q <= ST_FIX;
               end
            end
            ST_FIX: begin
               quot    <= quot_fix;
               rem     <= rem_fix;
               done    <= 1'b1;
               state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/div4q_chk.sv
module div4q_chk #(
   parameter int DW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start,
   input logic          busy,
   input logic          done,
   input logic [DW-1:0] quot,
   input logic [DW-1:0] rem
);
   localparam int LAT = DW + 1;
   localparam int KW  = $clog2(LAT + 2);

   logic [KW-1:0] busy_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_cnt <= '0;
      end else if (busy) begin
         busy_cnt <= busy_cnt + KW'(1);
      end else begin
         busy_cnt <= '0;
      end
   end

   // R2
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   // R2
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R2
   start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy);

   // R2
   latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (busy_cnt == KW'(LAT)));

   // R2
   busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);

   // R3
   no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start && (busy_cnt < KW'(LAT - 1))) |=> busy);

   // R7
   result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> ($stable(quot) && $stable(rem)));

endmodule

bind div4q_top div4q_chk #(.DW(DW)) i_div4q_chk (
   .clk  (clk),
   .rst_n(rst_n),
   .start(start),
   .busy (busy),
   .done (done),
   .quot (quot),
   .rem  (rem)
);

// File: tb/test_div4q_top.sv
`timescale 1ns/1ps
module test_div4q_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        frac_mode = 1'b0;
   logic [15:0] dvd_hi = '0;
   logic [15:0] dvd_lo = '0;
   logic [15:0] dvs = '0;
   logic        busy;
   logic        done;
   logic [15:0] quot;
   logic [15:0] rem;

   int n_total = 0;
   int n_fail  = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   div4q_top i_div4q_top (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .frac_mode(frac_mode),
      .dvd_hi   (dvd_hi),
      .dvd_lo   (dvd_lo),
      .dvs      (dvs),
      .busy     (busy),
      .done     (done),
      .quot     (quot),
      .rem      (rem)
   );

   function automatic logic [31:0] model(input logic [31:0] d, input logic [15:0] v,
                                          input bit frac);
      longint dd, vv, a, m, qm, rm, q, r;
      dd = longint'($signed(d));
      vv = longint'($signed(v));
      a  = (dd < 0) ? -dd : dd;
      m  = (vv < 0) ? -vv : vv;
      if (frac) a = a / 2;
      qm = a / m;
      rm = a % m;
      q  = ((dd < 0) != (vv < 0)) ? -qm : qm;
      r  = (dd < 0) ? -rm : rm;
      return {q[15:0], r[15:0]};
   endfunction

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_total++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // Launch one division, check timing and results.
   task automatic run_div(input string req, input logic [31:0] d, input logic [15:0] v,
                          input bit frac);
      logic [31:0] exp;
      int lat;
      exp = model(d, v, frac);
      @(negedge clk);
      dvd_hi = d[31:16]; dvd_lo = d[15:0]; dvs = v; frac_mode = frac; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      lat = 0;
      check("R2", "busy after start", {31'd0, busy}, 32'd1);
      while (!done && lat < 40) begin
         @(negedge clk);
         lat++;
      end
      check("R2", "done latency", lat, 17);
      check("R2", "busy low at done", {31'd0, busy}, 32'd0);
      check(req, "quotient", {16'd0, quot}, {16'd0, exp[31:16]});
      check(req, "remainder", {16'd0, rem}, {16'd0, exp[15:0]});
      @(negedge clk);
      check("R2", "done one cycle", {31'd0, done}, 32'd0);
   endtask

   task automatic t_reset();
      @(negedge clk);
      check("R1", "busy in reset", {31'd0, busy}, 32'd0);
      check("R1", "done in reset", {31'd0, done}, 32'd0);
      check("R1", "results in reset", {quot, rem}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", "state after reset", {14'd0, busy, done, quot}, 32'd0);
   endtask

   task automatic t_int_quadrants();
      run_div("R4_R5", 32'd100000, 16'd7, 1'b0);
      run_div("R4_R5", -32'sd100000, 16'd7, 1'b0);
      run_div("R4_R5", 32'd100000, -16'sd7, 1'b0);
      run_div("R4_R5", -32'sd100000, -16'sd7, 1'b0);
      run_div("R4_R5", 32'd12345678, 16'd1000, 1'b0);
      run_div("R4_R5", -32'sd12345678, -16'sd1000, 1'b0);
      run_div("R5", 32'd32767, -16'sd32768, 1'b0);
   endtask

   task automatic t_frac_quadrants();
      run_div("R6", 32'h2000_0000, 16'h4000, 1'b1);
      run_div("R6", -32'sh2000_0000, 16'h4000, 1'b1);
      run_div("R6", 32'd1000001, -16'sd300, 1'b1);
      run_div("R6", -32'sd1000001, -16'sd300, 1'b1);
      run_div("R6", -32'sd1000001, 16'sd300, 1'b1);
   endtask

   task automatic t_extremes();
      run_div("R8", 32'h8000_0000, 16'h8000, 1'b1);
      run_div("R8", 32'h8000_0000, 16'h7FFF, 1'b1);
      run_div("R8", 32'h8000_0001, 16'h8000, 1'b0);
      run_div("R8", 32'hC000_0000, 16'h8000, 1'b0);
   endtask

   task automatic t_zero();
      run_div("R9", 32'd0, -16'sd5, 1'b0);
      run_div("R9", 32'd0, 16'h8000, 1'b1);
   endtask

   task automatic t_busy_ignore();
      logic [31:0] exp;
      int lat;
      exp = model(32'd5000000, 16'd123, 1'b0);
      @(negedge clk);
      dvd_hi = 16'h004C; dvd_lo = 16'h4B40; dvs = 16'd123; frac_mode = 1'b0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      lat = 0;
      repeat (5) begin @(negedge clk); lat++; end
      dvd_hi = 16'hFFFF; dvd_lo = 16'h0001; dvs = 16'hFFF0; frac_mode = 1'b1; start = 1'b1;
      @(negedge clk); lat++;
      start = 1'b0;
      while (!done && lat < 40) begin @(negedge clk); lat++; end
      check("R3", "latency with mid-run start", lat, 17);
      check("R3", "result of first operands", {quot, rem}, exp);
      repeat (20) begin
         @(negedge clk);
         check("R3", "no second done", {31'd0, done}, 32'd0);
      end
   endtask

   task automatic t_hold();
      logic [31:0] held;
      run_div("R4", 32'd77777, 16'd55, 1'b0);
      held = {quot, rem};
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         dvd_hi = 16'(i * 311); dvd_lo = 16'(i * 97); dvs = 16'(i + 3); frac_mode = i[0];
         check("R7", "results held while idle", {quot, rem}, held);
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_total++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_total - n_fail, n_total);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      t_reset();
      t_int_quadrants();
      t_frac_quadrants();
      t_extremes();
      t_zero();
      t_busy_ignore();
      t_hold();
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
   end

endmodule